// File: doc/BRIEF.md
# Bit-Stuffing NRZI Line Transmitter

This block turns a stream of packet bits into line levels for a single-ended, unipolar serial line. Each bit is first run through a stuffing stage that inserts a 0 after every run of six consecutive 1 bits. The result then goes through an NRZI coder. In that coder a 0 flips the line level and a 1 keeps it, so the line changes level at least once in every seven bit times and the receiver's clock recovery stays locked.

Bits arrive on a valid/ready interface. Flags mark the first and the last bit of a packet. The coder advances only on cycles where the bit-rate enable is high, so one design can run at any bit rate below the system clock. When a stuffed bit occupies a slot, ready is held low for that slot and the pending data bit waits. A busy flag covers the packet from its first accepted bit until its final slot, including a trailing stuffed bit. Between packets the line rests at the idle level, which is high.

Top module: `usbStuffNrziTx`

## Requirements
- R1: In every coded slot, a 0 bit (data or stuffed) makes `lineOut` the inverse of its level in the previous slot, and a 1 bit keeps the previous level.
- R2: Within a packet, after six consecutive 1 bits have been coded, the next slot carries a stuffed 0 (a line toggle). A run of ten 1s yields exactly one stuffed bit.
- R3: `inReady` is low exactly during a slot that carries a stuffed bit. The held data bit is consumed in the following slot, so no data is lost.
- R4: The ones-run count returns to zero on any coded 0, including a stuffed one, and on the first bit of a packet. Five 1s, a 0, then five 1s produce no stuffed bit, and a run never carries over from one packet into the next.
- R5: `lineOut`, `busy` and the coder state change only on cycles where `bitEn` is high. Offered input is not consumed while `bitEn` is low.
- R6: After reset, and in any slot outside a packet, `lineOut` is high. The first bit of a packet (`inSop`=1) is coded against that high idle level.
- R7: If the last bit (`inEop`=1) completes a run of six 1s, a stuffed 0 is still sent in the next slot. `busy` stays high through that slot and drops after it.
- R8: `busy` goes high at the slot that consumes a packet's first bit and goes low at the slot that sends its final bit. A one-bit packet never raises `busy`.
- R9: Outside a packet, a valid bit without `inSop` is consumed and discarded: `lineOut` stays high and `busy` stays low.
- R10: Inside a packet, an enable slot with `inValid` low sends nothing. `lineOut` holds and the ones-run count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | One-cycle pulse per bit time; advances the coder |
| inValid | input | 1 | Input bit is offered |
| inBit | input | 1 | Packet data bit |
| inSop | input | 1 | Offered bit is the first of a packet |
| inEop | input | 1 | Offered bit is the last of a packet |
| inReady | output | 1 | Low while a stuffed bit occupies the slot |
| lineOut | output | 1 | Coded line level (high = idle) |
| busy | output | 1 | A packet is in progress |

## Verification
The bench targets the stuffing boundary. It sends runs of exactly five and six ones, a run of ten, and a packet whose last bit completes a six-run. A design that counts one bit too few or too many stuffs either early or not at all. A design that forgets the trailing case ends the packet with a run that has no transition. A second packet that starts right after one ending in ones exposes a counter that is not cleared on start of packet, which would show up as a spurious stuffed bit. Stalled slots, slots without the enable, and stray bits outside a packet check that nothing moves the line level when it should hold.

// File: rtl/usbTxPkg.sv
package usbTxPkg;

  // Strobes from the control to the line register, valid in bitEn slots.
  typedef struct packed {
    logic shift;    // code one bit this slot
    logic bitVal;   // value of the coded bit
    logic refIdle;  // code against the idle level instead of the current one
    logic goIdle;   // drive the idle level (outside a packet)
  } coderStrobeT;

endpackage

// File: rtl/nrziStuffCtrl.sv
module nrziStuffCtrl
  import usbTxPkg::*;
#(
  parameter int STUFF_RUN = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitEn,
  input  logic        inValid,
  input  logic        inBit,
  input  logic        inSop,
  input  logic        inEop,
  output logic        inReady,
  output logic        busy,
  output coderStrobeT strobe
);

  localparam int CW = $clog2(STUFF_RUN + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(STUFF_RUN);

  logic [CW-1:0] runQ, runD, runBase;
  logic          busyQ, busyD;
  logic          eopPendQ, eopPendD;
  logic          stuffPending;

  assign stuffPending = busyQ && (runQ == RUN_MAX);
  assign inReady      = !stuffPending;
  assign busy         = busyQ;

  always_comb begin
    runD     = runQ;
    busyD    = busyQ;
    eopPendD = eopPendQ;
    runBase  = inSop ? '0 : runQ;
    strobe   = '0;
    if (bitEn) begin
      if (stuffPending) begin
        strobe.shift  = 1'b1;
        strobe.bitVal = 1'b0;
        runD          = '0;
        if (eopPendQ) begin
          busyD    = 1'b0;
          eopPendD = 1'b0;
        end
      end else if (inValid && (inSop || busyQ)) begin
        strobe.shift   = 1'b1;
        strobe.bitVal  = inBit;
        strobe.refIdle = inSop;
        runD           = inBit ? runBase + 1'b1 : '0;
        if (inEop) begin
          busyD    = (runD == RUN_MAX);
          eopPendD = (runD == RUN_MAX);
        end else begin
          busyD    = 1'b1;
          eopPendD = 1'b0;
        end
      end else if (!busyQ) begin
        strobe.goIdle = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ     <= '0;
      busyQ    <= 1'b0;
      eopPendQ <= 1'b0;
    end else begin
      runQ     <= runD;
      busyQ    <= busyD;
      eopPendQ <= eopPendD;
    end
  end

  // R2: the ones-run count never exceeds the stuffing threshold
  p_run_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    runQ <= RUN_MAX);

  // R4: a stuffed slot clears the run count
  p_stuff_clears_run_r4: assert property (@(posedge clk) disable iff (!rstN)
    bitEn && stuffPending |=> runQ == '0);

  // R7: a stuffed bit owed to end of packet closes the packet
  p_eop_stuff_ends_r7: assert property (@(posedge clk) disable iff (!rstN)
    bitEn && stuffPending && eopPendQ |=> !busy);

  // R5: busy moves only in enable slots
  p_busy_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(busy));

endmodule

// File: rtl/nrziLineReg.sv
module nrziLineReg
  import usbTxPkg::*;
#(
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitEn,
  input  coderStrobeT strobe,
  output logic        lineOut
);

  logic lineQ;
  logic baseLevel;

  assign baseLevel = strobe.refIdle ? IDLE_LEVEL : lineQ;
  assign lineOut   = lineQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineQ <= IDLE_LEVEL;
    end else if (bitEn) begin
      if (strobe.shift)       lineQ <= strobe.bitVal ? baseLevel : ~baseLevel;
      else if (strobe.goIdle) lineQ <= IDLE_LEVEL;
    end
  end

  // R1: a 1 coded against the current level keeps it
  p_one_holds_r1: assert property (@(posedge clk) disable iff (!rstN)
    bitEn && strobe.shift && strobe.bitVal && !strobe.refIdle |=> $stable(lineQ));

  // R1: a 0 coded against the current level flips it
  p_zero_toggles_r1: assert property (@(posedge clk) disable iff (!rstN)
    bitEn && strobe.shift && !strobe.bitVal && !strobe.refIdle |=> lineQ != $past(lineQ));

  // R5: no movement without the bit-rate enable
  p_line_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(lineQ));

endmodule

// File: rtl/usbStuffNrziTx.sv
module usbStuffNrziTx
  import usbTxPkg::*;
#(
  parameter int   STUFF_RUN  = 6,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitEn,
  input  logic inValid,
  input  logic inBit,
  input  logic inSop,
  input  logic inEop,
  output logic inReady,
  output logic lineOut,
  output logic busy
);

  localparam int WW = $clog2(STUFF_RUN + 1) + 1;

  coderStrobeT strobe;

  nrziStuffCtrl #(.STUFF_RUN(STUFF_RUN)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .bitEn   (bitEn),
    .inValid (inValid),
    .inBit   (inBit),
    .inSop   (inSop),
    .inEop   (inEop),
    .inReady (inReady),
    .busy    (busy),
    .strobe  (strobe)
  );

  nrziLineReg #(.IDLE_LEVEL(IDLE_LEVEL)) line_i (
    .clk     (clk),
    .rstN    (rstN),
    .bitEn   (bitEn),
    .strobe  (strobe),
    .lineOut (lineOut)
  );

  // Coded slots since the last line transition, for the run-length check.
  logic [WW-1:0] sameCnt;
  logic          prevLine;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sameCnt  <= '0;
      prevLine <= IDLE_LEVEL;
    end else if (bitEn && strobe.shift) begin
      prevLine <= lineOut;
      if (strobe.refIdle)
        sameCnt <= strobe.bitVal ? WW'(1) : '0;
      else if (strobe.bitVal && sameCnt != '1)
        sameCnt <= sameCnt + 1'b1;
      else if (!strobe.bitVal)
        sameCnt <= '0;
    end
  end

  // R2: never more than STUFF_RUN coded slots without a transition
  p_transition_window_r2: assert property (@(posedge clk) disable iff (!rstN)
    sameCnt <= WW'(STUFF_RUN));

  // R2/R3: a slot that withholds ready carries a toggle
  p_stuff_toggles_r3: assert property (@(posedge clk) disable iff (!rstN)
    bitEn && !inReady |=> lineOut != $past(lineOut));

  // R6: outside a packet, an enable slot with no packet start leaves the line idle
  p_idle_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    bitEn && !busy && !(inValid && inSop) |=> lineOut == IDLE_LEVEL);

endmodule

// File: tb/usbStuffNrziTx_tb.sv
module usbStuffNrziTx_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0;
  logic inValid = 1'b0;
  logic inBit = 1'b0;
  logic inSop = 1'b0;
  logic inEop = 1'b0;
  logic inReady, lineOut, busy;

  always #10 clk = ~clk;

  usbStuffNrziTx dut_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .inValid(inValid), .inBit(inBit),
    .inSop(inSop), .inEop(inEop), .inReady(inReady), .lineOut(lineOut), .busy(busy)
  );

  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  // Behavioural model built from the requirements
  bit mLevel = 1'b1;
  int mRun = 0;
  bit mBusy = 1'b0;
  bit mEopPend = 1'b0;
  int stuffCount = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a negedge: one enable cycle, then back at a negedge with two quiet cycles.
  task automatic pulse();
    bitEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bitEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic modelSlot(input bit v, input bit b, input bit s, input bit e,
                           input string req, output bit consumed);
    bit stuff;
    bit base;
    stuff = mBusy && (mRun == 6);
    chk(inReady == !stuff, {req, "/R3 ready"}, int'(inReady), int'(!stuff));
    pulse();
    consumed = 1'b0;
    if (stuff) begin
      mLevel = ~mLevel;
      mRun = 0;
      stuffCount++;
      if (mEopPend) begin mBusy = 1'b0; mEopPend = 1'b0; end
    end else if (v && (s || mBusy)) begin
      base = s ? 1'b1 : mLevel;
      mLevel = b ? base : ~base;
      if (s) mRun = 0;
      mRun = b ? mRun + 1 : 0;
      if (e) begin mBusy = (mRun == 6); mEopPend = (mRun == 6); end
      else begin mBusy = 1'b1; mEopPend = 1'b0; end
      consumed = 1'b1;
    end else begin
      consumed = v;
      if (!mBusy) mLevel = 1'b1;
    end
    chk(lineOut == mLevel, {req, "/R1 line"}, int'(lineOut), int'(mLevel));
    chk(busy == mBusy, {req, "/R8 busy"}, int'(busy), int'(mBusy));
  endtask

  task automatic sendBit(input bit b, input bit s, input bit e, input string req);
    bit consumed;
    inValid = 1'b1; inBit = b; inSop = s; inEop = e;
    consumed = 1'b0;
    while (!consumed) modelSlot(1'b1, b, s, e, req, consumed);
    inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
  endtask

  task automatic idleSlot(input string req);
    bit consumed;
    inValid = 1'b0;
    modelSlot(1'b0, 1'b0, 1'b0, 1'b0, req, consumed);
  endtask

  // Sends bits[n-1] first.
  task automatic sendVec(input logic [31:0] bits, input int n, input string req);
    for (int i = n - 1; i >= 0; i--)
      sendBit(bits[i], i == n - 1, i == 0, req);
  endtask

  task automatic t_reset();
    chk(lineOut == 1'b1, "R6 reset line", int'(lineOut), 1);
    chk(busy == 1'b0, "R8 reset busy", int'(busy), 0);
    chk(inReady == 1'b1, "R3 reset ready", int'(inReady), 1);
  endtask

  task automatic t_basic();
    sendVec(32'b0010_1101_0011_0100, 16, "R1 basic");
    idleSlot("R6 after basic");
    chk(lineOut == 1'b1, "R6 idle after packet", int'(lineOut), 1);
  endtask

  task automatic t_stuff_ten();
    int s0;
    s0 = stuffCount;
    sendVec(32'b0_1111111111_0, 12, "R2 ten ones");
    idleSlot("R2 tail");
    chk(stuffCount - s0 == 1, "R2 ten ones stuff count", stuffCount - s0, 1);
  endtask

  task automatic t_five_zero_five();
    int s0;
    s0 = stuffCount;
    sendVec(32'b11111_0_11111_0, 12, "R4 five-zero-five");
    idleSlot("R4 tail");
    chk(stuffCount - s0 == 0, "R4 no stuff on five runs", stuffCount - s0, 0);
  endtask

  task automatic t_eop_stuff();
    int s0;
    s0 = stuffCount;
    sendVec(32'b0_111111, 7, "R7 eop six");
    chk(busy == 1'b1, "R7 busy held for trailing stuff", int'(busy), 1);
    chk(inReady == 1'b0, "R7 ready low before stuff", int'(inReady), 0);
    idleSlot("R7 stuff slot");
    chk(busy == 1'b0, "R7 busy after stuff", int'(busy), 0);
    chk(stuffCount - s0 == 1, "R7 trailing stuff count", stuffCount - s0, 1);
    idleSlot("R7 idle");
  endtask

  task automatic t_sop_reset();
    int s0;
    s0 = stuffCount;
    sendVec(32'b0_1111, 5, "R4 first packet");
    sendVec(32'b111, 3, "R4 second packet");
    idleSlot("R4 gap");
    chk(stuffCount - s0 == 0, "R4 run cleared by sop", stuffCount - s0, 0);
  endtask

  task automatic t_stall();
    bit lv;
    sendBit(1'b0, 1'b1, 1'b0, "R10 first");
    sendBit(1'b1, 1'b0, 1'b0, "R10 one");
    sendBit(1'b1, 1'b0, 1'b0, "R10 one");
    lv = lineOut;
    idleSlot("R10 stall");
    idleSlot("R10 stall");
    chk(lineOut == lv, "R10 line held in stall", int'(lineOut), int'(lv));
    for (int i = 0; i < 3; i++) sendBit(1'b1, 1'b0, 1'b0, "R10 resume");
    // run is 5 here; one more 1 must trigger a stuff (count not lost in stall)
    sendBit(1'b1, 1'b0, 1'b1, "R10 last");
    chk(inReady == 1'b0, "R10 run kept across stall", int'(inReady), 0);
    idleSlot("R10 stuff");
    idleSlot("R10 idle");
  endtask

  task automatic t_no_enable();
    inValid = 1'b1; inBit = 1'b0; inSop = 1'b1; inEop = 1'b0;
    repeat (4) @(negedge clk);
    chk(lineOut == 1'b1, "R5 line without enable", int'(lineOut), 1);
    chk(busy == 1'b0, "R5 busy without enable", int'(busy), 0);
    sendBit(1'b0, 1'b1, 1'b0, "R5 first");
    inValid = 1'b1; inBit = 1'b0; inSop = 1'b0;
    repeat (4) @(negedge clk);
    chk(lineOut == 1'b0, "R5 hold mid packet", int'(lineOut), 0);
    sendBit(1'b0, 1'b0, 1'b1, "R5 last");
    idleSlot("R5 idle");
  endtask

  task automatic t_orphan();
    sendBit(1'b0, 1'b0, 1'b0, "R9 stray");
    chk(lineOut == 1'b1, "R9 stray keeps line", int'(lineOut), 1);
    sendBit(1'b0, 1'b0, 1'b1, "R9 stray");
    chk(busy == 1'b0, "R9 stray keeps busy low", int'(busy), 0);
  endtask

  task automatic t_single();
    sendVec(32'b0, 1, "R8 single bit");
    chk(busy == 1'b0, "R8 single bit busy", int'(busy), 0);
    chk(lineOut == 1'b0, "R6 single bit vs idle", int'(lineOut), 0);
    idleSlot("R6 single idle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_stuff_ten();
    t_five_zero_five();
    t_eop_stuff();
    t_sop_reset();
    t_stall();
    t_no_enable();
    t_orphan();
    t_single();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChk++;
      nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

endmodule